// File: doc/BRIEF.md
# Segment Translation and Protection Checker

This block turns a segmented logical reference into a physical address and decides whether the reference is legal. A requester presents a segment number, an offset within that segment and the kind of access (read, write or instruction fetch). A small table held in registers gives each segment a base address, a length, three permission bits and a residency flag. A separate write port loads the table one entry at a time.

Each accepted request yields exactly one registered result on the following clock. The result is either a translated address with a valid strobe, or a fault strobe with a cause code. The range check, the per-type permission check and the residency check are all made in the same cycle, and a faulting request reports only the cause with the highest priority. Software uses the cause code to tell an illegal reference from a segment that is only swapped out and has to be loaded first.

Top module: `seg_xlate_unit`

## Requirements
- R1: While `rst` is high, `req_ready`, `xl_valid` and `flt_valid` are low, and every table entry is cleared to not present, with length 0, no permissions and base 0. On the first clock edge after `rst` falls, `req_ready` goes high and stays high.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Exactly one of `xl_valid` or `flt_valid` is then high for the single following cycle. With no accepted request, both are low in the next cycle.
- R3: On an accepted request that passes every check, `xl_valid` is high, `flt_cause` is 0 and `xl_paddr` equals the entry's base plus the zero-extended offset, modulo 2^PA_W.
- R4: A segment number equal to or above NUM_SEG faults with cause 1. This check ranks above every other check.
- R5: A segment whose present flag is 0 faults with cause 2. This check ranks above the permission and range checks.
- R6: Access type 0 (read) needs permission bit 0, type 1 (write) needs bit 1, type 2 (fetch) needs bit 2, and type 3 is never permitted. A missing permission faults with cause 3 and ranks above the range check.
- R7: An offset equal to or above the entry's length faults with cause 4. A length of 0 therefore faults on every offset.
- R8: While `flt_valid` is high, `xl_valid` is low, `xl_paddr` is 0 and `flt_cause` is non-zero. While `flt_valid` is low, `flt_cause` is 0. While `xl_valid` is low, `xl_paddr` is 0.
- R9: A table write on the same edge that accepts a request does not affect that request, which uses the old entry. The write does affect every later request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | SEG_ID_W | Segment number of the reference |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch, 3 reserved |
| tw_en | input | 1 | Table write enable |
| tw_idx | input | IDX_W | Entry to write |
| tw_base | input | PA_W | Base address for the entry |
| tw_len | input | OFF_W | Length for the entry |
| tw_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 fetch |
| tw_present | input | 1 | Residency flag for the entry |
| xl_valid | output | 1 | Translation succeeded this cycle |
| xl_paddr | output | PA_W | Physical address, 0 unless xl_valid |
| flt_valid | output | 1 | Request faulted this cycle |
| flt_cause | output | 3 | 0 none, 1 bad segment, 2 not present, 3 permission, 4 out of range |

## Verification
The assertions run on every cycle and cover the parts of the contract that depend only on the ports. They check that each accepted request gets exactly one outcome on the next cycle and that no outcome appears without a request. They check that a fault and a translation are never reported together, that the cause code and the address are held at zero when unused, that an out-of-range segment number always gives cause 1, and that access type 3 never translates. The parts that depend on table contents can only be shown by the bench scenarios: the priority between not present, permission and range on crafted entries, the zero-length case, address wrap-around, and a write that lands on the same edge as a request. The bench follows these with a behavioural model.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_BAD_SEG = 3'd1,
        FLT_ABSENT  = 3'd2,
        FLT_PERM    = 3'd3,
        FLT_BOUND   = 3'd4
    } flt_e;

    localparam int PERM_R = 0;
    localparam int PERM_W = 1;
    localparam int PERM_X = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int NUM_SEG = 8,
    parameter int OFF_W   = 16,
    parameter int PA_W    = 24,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PA_W-1:0]  wr_base,
    input  logic [OFF_W-1:0] wr_len,
    input  logic [2:0]       wr_perm,
    input  logic             wr_present,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PA_W-1:0]  rd_base,
    output logic [OFF_W-1:0] rd_len,
    output logic [2:0]       rd_perm,
    output logic             rd_present
);

    typedef struct packed {
        logic [PA_W-1:0]  base;
        logic [OFF_W-1:0] len;
        logic [2:0]       perm;
        logic             present;
    } ent_t;

    ent_t               tbl_d [NUM_SEG];
    ent_t               tbl_q [NUM_SEG];
    ent_t               wr_ent;
    ent_t               rd_ent;
    logic [NUM_SEG-1:0] hit;

    assign wr_ent = '{base: wr_base, len: wr_len, perm: wr_perm, present: wr_present};

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_dec
        assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    always_comb begin
        for (int i = 0; i < NUM_SEG; i++) begin
            tbl_d[i] = hit[i] ? wr_ent : tbl_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SEG; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NUM_SEG; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    // Read port sees the registered table, so a same-edge write is invisible.
    if ((1 << IDX_W) > NUM_SEG) begin : g_rd_guard
        assign rd_ent = (int'(rd_idx) < NUM_SEG) ? tbl_q[rd_idx] : '0;
    end else begin : g_rd_full
        assign rd_ent = tbl_q[rd_idx];
    end

    assign rd_base    = rd_ent.base;
    assign rd_len     = rd_ent.len;
    assign rd_perm    = rd_ent.perm;
    assign rd_present = rd_ent.present;

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG  = 8,
    parameter int SEG_ID_W = 4,
    parameter int OFF_W    = 16,
    parameter int PA_W     = 24
) (
    input  logic [SEG_ID_W-1:0] seg_id,
    input  logic [OFF_W-1:0]    offset,
    input  logic [1:0]          acc,
    input  logic [PA_W-1:0]     base,
    input  logic [OFF_W-1:0]    len,
    input  logic [2:0]          perm,
    input  logic                present,
    output flt_e                cause,
    output logic [PA_W-1:0]     paddr
);

    logic id_bad;
    logic perm_ok;
    logic in_range;

    assign id_bad   = int'(seg_id) >= NUM_SEG;
    assign in_range = offset < len;
    assign paddr    = base + PA_W'(offset);

    always_comb begin
        unique case (acc_e'(acc))
            ACC_READ:  perm_ok = perm[PERM_R];
            ACC_WRITE: perm_ok = perm[PERM_W];
            ACC_EXEC:  perm_ok = perm[PERM_X];
            default:   perm_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (id_bad)         cause = FLT_BAD_SEG;
        else if (!present)  cause = FLT_ABSENT;
        else if (!perm_ok)  cause = FLT_PERM;
        else if (!in_range) cause = FLT_BOUND;
        else                cause = FLT_NONE;
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int NUM_SEG  = 8,
    parameter int SEG_ID_W = 4,
    parameter int OFF_W    = 16,
    parameter int PA_W     = 24,
    localparam int IDX_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [SEG_ID_W-1:0] req_seg,
    input  logic [OFF_W-1:0]    req_off,
    input  logic [1:0]          req_acc,
    input  logic                tw_en,
    input  logic [IDX_W-1:0]    tw_idx,
    input  logic [PA_W-1:0]     tw_base,
    input  logic [OFF_W-1:0]    tw_len,
    input  logic [2:0]          tw_perm,
    input  logic                tw_present,
    output logic                xl_valid,
    output logic [PA_W-1:0]     xl_paddr,
    output logic                flt_valid,
    output logic [2:0]          flt_cause
);

    typedef struct packed {
        logic            ready;
        logic            xl_valid;
        logic [PA_W-1:0] paddr;
        logic            flt_valid;
        flt_e            cause;
    } resp_t;

    resp_t            r_d;
    resp_t            r_q;
    logic             fire;
    logic [PA_W-1:0]  ent_base;
    logic [OFF_W-1:0] ent_len;
    logic [2:0]       ent_perm;
    logic             ent_present;
    flt_e             chk_cause;
    logic [PA_W-1:0]  chk_paddr;

    assign fire = req_valid && r_q.ready;

    seg_table #(
        .NUM_SEG (NUM_SEG),
        .OFF_W   (OFF_W),
        .PA_W    (PA_W),
        .IDX_W   (IDX_W)
    ) u_table (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (tw_en),
        .wr_idx     (tw_idx),
        .wr_base    (tw_base),
        .wr_len     (tw_len),
        .wr_perm    (tw_perm),
        .wr_present (tw_present),
        .rd_idx     (req_seg[IDX_W-1:0]),
        .rd_base    (ent_base),
        .rd_len     (ent_len),
        .rd_perm    (ent_perm),
        .rd_present (ent_present)
    );

    seg_check #(
        .NUM_SEG  (NUM_SEG),
        .SEG_ID_W (SEG_ID_W),
        .OFF_W    (OFF_W),
        .PA_W     (PA_W)
    ) u_check (
        .seg_id  (req_seg),
        .offset  (req_off),
        .acc     (req_acc),
        .base    (ent_base),
        .len     (ent_len),
        .perm    (ent_perm),
        .present (ent_present),
        .cause   (chk_cause),
        .paddr   (chk_paddr)
    );

    always_comb begin
        r_d           = '0;
        r_d.ready     = 1'b1;
        r_d.cause     = FLT_NONE;
        if (fire) begin
            r_d.cause     = chk_cause;
            r_d.flt_valid = (chk_cause != FLT_NONE);
            r_d.xl_valid  = (chk_cause == FLT_NONE);
            r_d.paddr     = (chk_cause == FLT_NONE) ? chk_paddr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = r_q.ready;
    assign xl_valid  = r_q.xl_valid;
    assign xl_paddr  = r_q.paddr;
    assign flt_valid = r_q.flt_valid;
    assign flt_cause = r_q.cause;

endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk #(
    parameter int NUM_SEG  = 8,
    parameter int SEG_ID_W = 4,
    parameter int PA_W     = 24
) (
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic [SEG_ID_W-1:0] req_seg,
    input logic [1:0]          req_acc,
    input logic                xl_valid,
    input logic [PA_W-1:0]     xl_paddr,
    input logic                flt_valid,
    input logic [2:0]          flt_cause
);

    assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
        !(xl_valid && flt_valid));

    assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (xl_valid || flt_valid));

    assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_ready) |=> !(xl_valid || flt_valid));

    assert_bad_seg_first_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (int'(req_seg) >= NUM_SEG))
        |=> (flt_valid && flt_cause == 3'd1));

    assert_rsvd_acc_never_ok_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_acc == 2'd3) |=> !xl_valid);

    assert_cause_matches_fault_R8: assert property (@(posedge clk) disable iff (rst)
        flt_valid == (flt_cause != 3'd0));

    assert_paddr_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !xl_valid |-> (xl_paddr == '0));

endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(
    .NUM_SEG  (NUM_SEG),
    .SEG_ID_W (SEG_ID_W),
    .PA_W     (PA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_seg   (req_seg),
    .req_acc   (req_acc),
    .xl_valid  (xl_valid),
    .xl_paddr  (xl_paddr),
    .flt_valid (flt_valid),
    .flt_cause (flt_cause)
);

// File: tb/seg_xlate_unit_bench.sv
module seg_xlate_unit_bench;

    localparam int NSEG  = 8;
    localparam int SW    = 4;
    localparam int OW    = 16;
    localparam int PW    = 24;
    localparam int IW    = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [SW-1:0] req_seg = '0;
    logic [OW-1:0] req_off = '0;
    logic [1:0]    req_acc = '0;
    logic          tw_en = 1'b0;
    logic [IW-1:0] tw_idx = '0;
    logic [PW-1:0] tw_base = '0;
    logic [OW-1:0] tw_len = '0;
    logic [2:0]    tw_perm = '0;
    logic          tw_present = 1'b0;
    logic          xl_valid;
    logic [PW-1:0] xl_paddr;
    logic          flt_valid;
    logic [2:0]    flt_cause;

    always #4 clk = ~clk;

    seg_xlate_unit u_seg_xlate_unit (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_seg    (req_seg),
        .req_off    (req_off),
        .req_acc    (req_acc),
        .tw_en      (tw_en),
        .tw_idx     (tw_idx),
        .tw_base    (tw_base),
        .tw_len     (tw_len),
        .tw_perm    (tw_perm),
        .tw_present (tw_present),
        .xl_valid   (xl_valid),
        .xl_paddr   (xl_paddr),
        .flt_valid  (flt_valid),
        .flt_cause  (flt_cause)
    );

    // Behavioural reference: table contents and expected next outputs.
    int    m_base [NSEG];
    int    m_len  [NSEG];
    int    m_perm [NSEG];
    int    m_pres [NSEG];
    int    e_ready, e_xv, e_fv, e_cause, e_pa;
    bit    have_exp = 1'b0;
    bit    e_in_rst = 1'b0;
    bit    e_fire   = 1'b0;
    string note = "";
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    function automatic int ref_cause(int seg, int off, int acc);
        int need;
        if (seg >= NSEG) return 1;
        if (m_pres[seg] == 0) return 2;
        need = (acc == 3) ? -1 : acc;
        if (need < 0 || ((m_perm[seg] >> need) & 1) == 0) return 3;
        if (off >= m_len[seg]) return 4;
        return 0;
    endfunction

    // Snapshot one ns before each rising edge; predicts what that edge produces.
    always begin
        @(negedge clk);
        #3;
        e_in_rst = rst;
        if (rst) begin
            for (int i = 0; i < NSEG; i++) begin
                m_base[i] = 0; m_len[i] = 0; m_perm[i] = 0; m_pres[i] = 0;
            end
            e_ready = 0; e_xv = 0; e_fv = 0; e_cause = 0; e_pa = 0;
            e_fire  = 1'b0;
        end else begin
            e_fire  = req_valid && (req_ready === 1'b1);
            e_ready = 1;
            e_xv = 0; e_fv = 0; e_cause = 0; e_pa = 0;
            if (e_fire) begin
                e_cause = ref_cause(int'(req_seg), int'(req_off), int'(req_acc));
                if (e_cause == 0) begin
                    e_xv = 1;
                    e_pa = (m_base[req_seg] + int'(req_off)) % (1 << PW);
                end else begin
                    e_fv = 1;
                end
            end
            if (tw_en) begin
                m_base[tw_idx] = int'(tw_base);
                m_len[tw_idx]  = int'(tw_len);
                m_perm[tw_idx] = int'(tw_perm);
                m_pres[tw_idx] = int'(tw_present);
            end
        end
        have_exp = 1'b1;
    end

    // Compare two ns after each rising edge.
    always begin
        string tag;
        @(posedge clk);
        #2;
        if (have_exp && !done) begin
            n_chk++;
            if (e_in_rst)        tag = "R1";
            else if (!e_fire)    tag = "R2";
            else if (e_cause==0) tag = "R3";
            else if (e_cause==1) tag = "R4/R8";
            else if (e_cause==2) tag = "R5/R8";
            else if (e_cause==3) tag = "R6/R8";
            else                 tag = "R7/R8";
            if (req_ready !== e_ready[0]) begin
                n_fail++;
                $display("FAIL R1 %s ready act=%b exp=%0d", note, req_ready, e_ready);
            end else if (xl_valid !== e_xv[0] || flt_valid !== e_fv[0] ||
                         flt_cause !== 3'(e_cause) || xl_paddr !== PW'(e_pa)) begin
                n_fail++;
                $display("FAIL %s %s act xv=%b fv=%b cause=%0d pa=%h exp xv=%0d fv=%0d cause=%0d pa=%h",
                         tag, note, xl_valid, flt_valid, flt_cause, xl_paddr,
                         e_xv, e_fv, e_cause, PW'(e_pa));
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        tw_en     = 1'b0;
    endtask

    task automatic req(input int seg, input int off, input int acc);
        @(negedge clk);
        tw_en     = 1'b0;
        req_valid = 1'b1;
        req_seg   = SW'(seg);
        req_off   = OW'(off);
        req_acc   = 2'(acc);
    endtask

    task automatic wr(input int idx, input int base, input int len, input int perm, input int pres);
        @(negedge clk);
        req_valid  = 1'b0;
        tw_en      = 1'b1;
        tw_idx     = IW'(idx);
        tw_base    = PW'(base);
        tw_len     = OW'(len);
        tw_perm    = 3'(perm);
        tw_present = pres[0];
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        idle();
        note = "R1 empty table";
        req(0, 0, 0);
        req(7, 5, 2);
        note = "R3";
        wr(2, 'h100000, 'h40, 3, 1);
        req(2, 'h3F, 0);
        req(2, 0, 1);
        note = "R7 boundary";
        req(2, 'h40, 0);
        note = "R6";
        req(2, 5, 2);
        req(2, 5, 3);
        note = "R4";
        req(9, 0, 0);
        req(15, 'hFFFF, 3);
        note = "R5 priority";
        wr(3, 'h2000, 0, 0, 0);
        req(3, 'h10, 3);
        note = "R6 over range";
        wr(4, 'h3000, 0, 0, 1);
        req(4, 'h99, 0);
        note = "R7 zero length";
        wr(5, 'h4000, 0, 7, 1);
        req(5, 0, 2);
        note = "R3 wrap";
        wr(6, 'hFFFFF0, 'hFFFF, 7, 1);
        req(6, 'h20, 2);
        note = "R9 same-edge write";
        @(negedge clk);
        req_valid = 1'b1; req_seg = 4'd2; req_off = 16'h10; req_acc = 2'd0;
        tw_en = 1'b1; tw_idx = 3'd2; tw_base = '0; tw_len = '0; tw_perm = '0; tw_present = 1'b0;
        req(2, 'h10, 0);
        idle();
        note = "random";
        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            req_valid  = ($urandom_range(0, 3) != 0);
            req_seg    = SW'($urandom_range(0, 10));
            req_off    = OW'(($urandom_range(0, 1) != 0) ? $urandom_range(0, 80) : $urandom);
            req_acc    = 2'($urandom_range(0, 3));
            tw_en      = ($urandom_range(0, 5) == 0);
            tw_idx     = IW'($urandom_range(0, NSEG - 1));
            tw_base    = PW'($urandom);
            tw_len     = OW'($urandom_range(0, 64));
            tw_perm    = 3'($urandom_range(0, 7));
            tw_present = ($urandom_range(0, 4) != 0);
        end
        idle();
        idle();
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule